// File: doc/BRIEF.md
# Byte-Fed CRC16 Register Block

This block computes a 16-bit cyclic redundancy check with the generator polynomial 0x1021, fed one byte at a time through a small register bus. Software first chooses which half of the 16-bit value the byte-wide seed and result addresses reach, using a 2-bit select field. It then writes the two seed bytes and streams data bytes into the data port. Each accepted byte advances the working remainder in a single clock, so the result can be read on the very next cycle.

A second byte source, a scan input meant for a memory checking engine, takes over the data path when the select field holds the scan code. While that code is set, bytes written by the processor to the data port are dropped. A separate mirror register sits next to the checker. It hands back any byte written to it with its bit order reversed.

Register addresses (3 bits): 0 control (select field in bits 1:0), 1 data input (write only), 2 seed byte (write only), 3 result byte (read only), 4 mirror. Unused addresses and write-only addresses read as zero.

Top module: `crc16_byte_regs`

## Requirements
- R1: After reset the remainder is 0xFFFF, the select field is 00 and the mirror register reads 0x00.
- R2: A write to address 0 stores wdata bits 1:0 as the select field; reading address 0 returns it in bits 1:0 with bits 7:2 zero.
- R3: A write to address 2 loads the byte into the working remainder, into bits 7:0 when select bit 0 is 0 and into bits 15:8 when it is 1, and leaves the other half unchanged.
- R4: With select 00 or 01, a write to address 1 advances the remainder by one byte, MSB first, no reflection, polynomial 0x1021, and the new value is readable in the cycle after the write.
- R5: Address 3 returns remainder bits 7:0 when select is 00 and bits 15:8 when select is 01 or 11, with no final XOR.
- R6: Seed 0xFFFF followed by the ASCII bytes "123456789" leaves the remainder 0x29B1.
- R7: With select 11, writes to address 1 do not change the remainder.
- R8: With select 11, each cycle with scan_valid high advances the remainder by scan_byte. With any other select, scan_valid has no effect.
- R9: Reading address 4 returns the last byte written there with bit i moved to bit 7-i.
- R10: With select 10, seed writes are ignored and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational from register state |
| scan_valid | input | 1 | Scan-path byte valid |
| scan_byte | input | 8 | Scan-path data byte |

## Verification
The remainder has two possible sources of a byte step: the processor data write and the scan input. With select 11, the bench raises scan_valid in the same cycle as a processor write to the data port. It then checks that only the scan byte reached the remainder, by reading both result halves against its model. The reverse case is also covered: with select 00, a scan pulse arrives alongside a processor write, and only the processor byte may count.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    SEL_LO   = 2'b00,
    SEL_HI   = 2'b01,
    SEL_RSV  = 2'b10,
    SEL_SCAN = 2'b11
  } sel_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEED = 3'd2;
  localparam logic [ADDR_W-1:0] A_RES  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MIRR = 3'd4;
endpackage

// File: rtl/crc16_rst_sync.sv
module crc16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/crc16_byte_step.sv
// One full byte step of an MSB-first CRC, unrolled into DATA_W bit stages.
module crc16_byte_step #(
  parameter int          CRC_W  = 16,
  parameter int          DATA_W = 8,
  parameter logic [15:0] POLY   = 16'h1021
) (
  input  logic [CRC_W-1:0]  rem_in,
  input  logic [DATA_W-1:0] byte_in,
  output logic [CRC_W-1:0]  rem_out
);
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = rem_in;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic feedback;
    assign feedback = stage[i][CRC_W-1] ^ byte_in[DATA_W-1-i];
    assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^
                        (feedback ? POLY[CRC_W-1:0] : '0);
  end

  assign rem_out = stage[DATA_W];
endmodule

// File: rtl/crc16_state.sv
module crc16_state
  import crc16_pkg::*;
#(
  parameter int               CRC_W    = 16,
  parameter int               DATA_W   = 8,
  parameter logic [15:0]      POLY     = 16'h1021,
  parameter logic [CRC_W-1:0] REM_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_e              sel,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_byte,
  input  logic              seed_wr,
  input  logic [DATA_W-1:0] seed_byte,
  input  logic              scan_valid,
  input  logic [DATA_W-1:0] scan_byte,
  output logic [CRC_W-1:0]  rem
);
  localparam int HALF_LSB = DATA_W;

  logic              scan_mode;
  logic              step_en;
  logic              seed_en;
  logic              load_en;
  logic [DATA_W-1:0] step_byte;
  logic [CRC_W-1:0]  step_out;
  logic [CRC_W-1:0]  rem_nxt;

  assign scan_mode = (sel == SEL_SCAN);
  assign step_byte = scan_mode ? scan_byte : cpu_byte;
  assign step_en   = scan_mode ? scan_valid : cpu_wr;
  assign seed_en   = seed_wr && (sel != SEL_RSV);
  assign load_en   = seed_en || step_en;

  crc16_byte_step #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W),
    .POLY  (POLY)
  ) step_i (
    .rem_in (rem),
    .byte_in(step_byte),
    .rem_out(step_out)
  );

  always_comb begin
    rem_nxt = rem;
    if (seed_en) begin
      if (sel[0]) rem_nxt[CRC_W-1:HALF_LSB] = seed_byte;
      else        rem_nxt[HALF_LSB-1:0]     = seed_byte;
    end else if (step_en) begin
      rem_nxt = step_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rem <= REM_INIT;
    else if (load_en) rem <= rem_nxt;
  end

  // R7: processor data bytes are dropped in scan mode
  a_r7_cpu_dropped_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_SCAN && cpu_wr && !scan_valid && !seed_wr) |=> $stable(rem));

  // R8: scan bytes are dropped outside scan mode
  a_r8_scan_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SEL_SCAN && scan_valid && !cpu_wr && !seed_wr) |=> $stable(rem));

  // R3: low seed write touches only the low half
  a_r3_seed_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_wr && sel == SEL_LO) |=>
      (rem[HALF_LSB-1:0] == $past(seed_byte)) &&
      (rem[CRC_W-1:HALF_LSB] == $past(rem[CRC_W-1:HALF_LSB])));

  // R10: reserved select blocks seed writes
  a_r10_rsv_seed_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_RSV && seed_wr && !cpu_wr) |=> $stable(rem));
endmodule

// File: rtl/crc16_bit_mirror.sv
module crc16_bit_mirror #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] held_q;
  logic [DATA_W-1:0] held_nxt;

  assign held_nxt = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held_q <= '0;
    else if (we) held_q <= held_nxt;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    assign dout[i] = held_q[DATA_W-1-i];
  end
endmodule

// File: rtl/crc16_byte_regs.sv
module crc16_byte_regs
  import crc16_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter int          CRC_W  = 16,
  parameter logic [15:0] POLY   = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              scan_valid,
  input  logic [DATA_W-1:0] scan_byte
);
  localparam int SEL_W = 2;

  logic              rst_sync_n;
  sel_e              sel_q;
  sel_e              sel_nxt;
  logic              ctrl_we;
  logic              data_we;
  logic              seed_we;
  logic              mirr_we;
  logic [CRC_W-1:0]  rem;
  logic [DATA_W-1:0] mirr_out;
  logic [DATA_W-1:0] res_byte;

  crc16_rst_sync #(.STAGES(2)) rst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  assign ctrl_we = wr_en && (addr == A_CTRL);
  assign data_we = wr_en && (addr == A_DATA);
  assign seed_we = wr_en && (addr == A_SEED);
  assign mirr_we = wr_en && (addr == A_MIRR);

  assign sel_nxt = sel_e'(wdata[SEL_W-1:0]);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   sel_q <= SEL_LO;
    else if (ctrl_we)  sel_q <= sel_nxt;
  end

  crc16_state #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W),
    .POLY  (POLY)
  ) state_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel       (sel_q),
    .cpu_wr    (data_we),
    .cpu_byte  (wdata),
    .seed_wr   (seed_we),
    .seed_byte (wdata),
    .scan_valid(scan_valid),
    .scan_byte (scan_byte),
    .rem       (rem)
  );

  crc16_bit_mirror #(.DATA_W(DATA_W)) mirr_i (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .we   (mirr_we),
    .din  (wdata),
    .dout (mirr_out)
  );

  always_comb begin
    if (sel_q == SEL_RSV) res_byte = '0;
    else if (sel_q[0])    res_byte = rem[CRC_W-1:DATA_W];
    else                  res_byte = rem[DATA_W-1:0];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[SEL_W-1:0] = sel_q;
      A_RES:   rdata = res_byte;
      A_MIRR:  rdata = mirr_out;
      default: rdata = '0;
    endcase
  end

  // R2: select field only moves on a control write
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_we |=> $stable(sel_q));
endmodule

// File: tb/crc16_byte_regs_tb_top.sv
module crc16_byte_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       scan_valid;
  logic [7:0] scan_byte;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int m_rem, m_sel, m_mir;

  always #5 clk = ~clk;

  crc16_byte_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .scan_valid(scan_valid), .scan_byte(scan_byte)
  );

  function automatic int crc_step(int r, int b);
    int x = r ^ ((b & 255) << 8);
    for (int k = 0; k < 8; k++) begin
      if ((x & 32'h8000) != 0) x = ((x << 1) ^ 32'h1021) & 32'hFFFF;
      else                     x = (x << 1) & 32'hFFFF;
    end
    return x;
  endfunction

  function automatic int flip8(int d);
    int o = 0;
    for (int k = 0; k < 8; k++) if (((d >> k) & 1) != 0) o |= (1 << (7 - k));
    return o;
  endfunction

  function automatic int model_read(int a);
    case (a)
      0: return m_sel;
      3: begin
        if (m_sel == 2) return 0;
        if ((m_sel & 1) != 0) return (m_rem >> 8) & 255;
        return m_rem & 255;
      end
      4: return flip8(m_mir);
      default: return 0;
    endcase
  endfunction

  task automatic model_write(int a, int d);
    case (a)
      0: m_sel = d & 3;
      1: if (m_sel != 3) m_rem = crc_step(m_rem, d);
      2: if (m_sel != 2) begin
        if ((m_sel & 1) != 0) m_rem = (m_rem & 32'h00FF) | ((d & 255) << 8);
        else                  m_rem = (m_rem & 32'hFF00) | (d & 255);
      end
      4: m_mir = d & 255;
      default: ;
    endcase
  endtask

  task automatic chk(int a, string tag);
    int exp;
    @(negedge clk);
    wr_en = 1'b0;
    addr  = a[2:0];
    #1;
    exp = model_read(a);
    n_run++;
    if (int'(rdata) != exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_const(int a, int exp, string tag);
    @(negedge clk);
    wr_en = 1'b0;
    addr  = a[2:0];
    #1;
    n_run++;
    if (int'(rdata) != exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, rdata, exp);
    end
  endtask

  task automatic bus_wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[2:0]; wdata = d[7:0];
    @(posedge clk);
    #1;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // scan pulse, optionally colliding with a processor data write
  task automatic scan_pulse(int b, bit with_cpu, int cb);
    @(negedge clk);
    scan_valid = 1'b1; scan_byte = b[7:0];
    if (with_cpu) begin wr_en = 1'b1; addr = 3'd1; wdata = cb[7:0]; end
    @(posedge clk);
    #1;
    if (m_sel == 3) m_rem = crc_step(m_rem, b);
    else if (with_cpu) m_rem = crc_step(m_rem, cb);
    @(negedge clk);
    scan_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic chk_both(string tag);
    int keep = m_sel;
    bus_wr(0, 0); chk(3, tag);
    bus_wr(0, 1); chk(3, tag);
    bus_wr(0, keep);
  endtask

  initial begin
    wr_en = 0; addr = 0; wdata = 0; scan_valid = 0; scan_byte = 0;
    m_rem = 32'hFFFF; m_sel = 0; m_mir = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    chk_const(3, 8'hFF, "R1 result low");
    chk_const(0, 0, "R1 select");
    chk_const(4, 0, "R1 mirror");
    bus_wr(0, 1);
    chk_const(3, 8'hFF, "R1 result high");

    // R2 control readback
    bus_wr(0, 8'hFD);
    chk_const(0, 1, "R2 select bits");
    chk(1, "R2 data reads zero");

    // R3 and R5 seed halves
    bus_wr(0, 0); bus_wr(2, 8'h34);
    chk_const(3, 8'h34, "R3 low seed");
    bus_wr(0, 1); bus_wr(2, 8'h12);
    chk_const(3, 8'h12, "R5 high byte");
    bus_wr(0, 0);
    chk_const(3, 8'h34, "R3 low kept");

    // R4 single byte steps
    bus_wr(1, 8'hA5); chk_both("R4 step A5");
    bus_wr(1, 8'h00); bus_wr(1, 8'hFF); chk_both("R4 steps 00 FF");

    // R6 check value
    bus_wr(0, 0); bus_wr(2, 8'hFF);
    bus_wr(0, 1); bus_wr(2, 8'hFF);
    for (int i = 0; i < 9; i++) bus_wr(1, 8'h31 + i);
    chk_const(3, 8'h29, "R6 high byte");
    bus_wr(0, 0);
    chk_const(3, 8'hB1, "R6 low byte");

    // R7 processor data dropped in scan mode
    bus_wr(0, 3);
    bus_wr(1, 8'h5A); bus_wr(1, 8'hC3);
    chk(3, "R7 high after cpu writes");
    chk_both("R7 both halves");

    // R8 scan path, including collision with processor write
    bus_wr(0, 3);
    scan_pulse(8'h31, 0, 0);
    scan_pulse(8'h7E, 1, 8'h99);
    chk_both("R8 scan with collision");
    bus_wr(0, 0);
    scan_pulse(8'h44, 0, 0);
    chk_both("R8 scan ignored");
    scan_pulse(8'h44, 1, 8'h17);
    chk_both("R8 cpu wins outside scan");

    // R9 mirror
    bus_wr(4, 8'h01); chk_const(4, 8'h80, "R9 01");
    bus_wr(4, 8'hB4); chk_const(4, 8'h2D, "R9 B4");
    bus_wr(4, 8'h6E); chk(4, "R9 6E");

    // R10 reserved select
    bus_wr(0, 2);
    chk_const(3, 0, "R10 read zero");
    bus_wr(2, 8'hAB);
    chk_both("R10 seed ignored");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule